// File: doc/BRIEF.md
# Base-and-Bounds Address Translator

This unit sits between a processor's load/store port and physical memory. Each virtual address the processor issues is compared against a size limit. If it is inside the limit it is relocated by adding a base offset, and the relocated request is passed on to memory. If it is outside the limit, nothing goes to memory and an out-of-range exception pulse is raised instead. Every program therefore sees its own address space starting at zero, and it cannot reach memory that belongs to anyone else.

The offset and the limit live in two registers. Software loads both through a configuration write port, but only while the processor's privileged-mode input is high. A write attempted in user mode changes nothing and raises its own exception pulse. While privileged mode is asserted, a read-back port shows the current offset and limit, so that context-switch code can save them and restore them later. The limit register is one bit wider than the virtual address, so a space covering the whole virtual range can be described.

Top module: `bb_xlate`

## Requirements
- R1: For an accepted request, `mem_paddr_o` equals the virtual address plus the base register, modulo 2^PA_W. `mem_valid_o` and `mem_write_o` (1 = store, 0 = load) appear exactly one clock after the request is sampled.
- R2: A request whose zero-extended virtual address is greater than or equal to the bounds register drives `fault_bounds_o` high for exactly one cycle, in the cycle where its translation would have appeared. `mem_valid_o` stays low in that cycle.
- R3: Translation and bounds checking apply to every request whatever the level of `priv_i`. No path bypasses them.
- R4: A configuration write with `priv_i` high loads both registers at the clock edge. A request sampled at that same edge is translated and checked with the old values. The new values apply from the next cycle.
- R5: A configuration write with `priv_i` low leaves both registers unchanged and pulses `fault_priv_o` high for exactly one cycle, one clock after the attempt.
- R6: After reset the base and bounds registers are zero, so every request faults until privileged software loads them. All outputs are low.
- R7: While `priv_i` is high, `cfg_base_o` and `cfg_bound_o` show the current register values. While it is low, both read as zero.
- R8: A cycle with no request produces neither `mem_valid_o` nor `fault_bounds_o` in the following cycle.
- R9: A bounds value of 2^VA_W makes every virtual address legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | Processor is in privileged mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_base_i | input | PA_W | New base value |
| cfg_bound_i | input | BD_W | New bounds value |
| cfg_base_o | output | PA_W | Base read-back (zero outside privileged mode) |
| cfg_bound_o | output | BD_W | Bounds read-back (zero outside privileged mode) |
| req_valid_i | input | 1 | Processor access request |
| req_vaddr_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | 1 = store, 0 = load |
| mem_valid_o | output | 1 | Translated request to memory |
| mem_paddr_o | output | PA_W | Physical address |
| mem_write_o | output | 1 | Store flag passed through |
| fault_bounds_o | output | 1 | Out-of-bounds exception pulse |
| fault_priv_o | output | 1 | Privilege-violation exception pulse |

## Verification
The bench uses a narrow configuration: 6-bit virtual addresses, 8-bit physical addresses and a 7-bit bounds register. This keeps every sweep exhaustive.

- The bench first sweeps all virtual addresses under a small base and a small limit. This shows where the limit comparison sits: it separates a greater-or-equal comparison from a strict one at the exact limit value.
- A second sweep uses a base near the top of the physical range together with the full-size limit. It exercises wrap-around of the sum and the extra bit of the bounds register.
- Alternating the privilege level and the store flag during the sweeps shows that no user-mode bypass exists and that the flag is carried through intact.
- Configuration writes are checked in both modes. A write arriving in the same cycle as an access shows whether the old or the new values are used.

// File: rtl/bb_pkg.sv
package bb_pkg;
    // Default geometry: 16-bit virtual, 20-bit physical, bounds one bit wider than virtual.
    localparam int unsigned VA_W_DEF = 16;
    localparam int unsigned PA_W_DEF = 20;
    localparam int unsigned BD_W_DEF = VA_W_DEF + 1;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/bb_regs.sv
module bb_regs #(
    parameter int unsigned PA_W = bb_pkg::PA_W_DEF,
    parameter int unsigned BD_W = bb_pkg::BD_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            priv_i,
    input  logic            we_i,
    input  logic [PA_W-1:0] base_i,
    input  logic [BD_W-1:0] bound_i,
    output logic [PA_W-1:0] base_o,
    output logic [BD_W-1:0] bound_o,
    output logic            priv_fault_o
);
    typedef struct packed {
        logic [PA_W-1:0] base;
        logic [BD_W-1:0] bound;
        logic            pfault;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pfault = 1'b0;
        if (we_i) begin
            if (priv_i) begin
                st_d.base  = base_i;
                st_d.bound = bound_i;
            end else begin
                st_d.pfault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o       = st_q.base;
    assign bound_o      = st_q.bound;
    assign priv_fault_o = st_q.pfault;

    // R4/R5: registers move only on a privileged write
    assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && priv_i) |=> $stable(base_o) && $stable(bound_o));

    // R4: privileged write lands next cycle
    assert_priv_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && priv_i) |=> base_o == $past(base_i) && bound_o == $past(bound_i));

    // R5: user write raises the privilege fault
    assert_user_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !priv_i) |=> priv_fault_o);

    assert_no_spurious_pfault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && !priv_i) |=> !priv_fault_o);
endmodule

// File: rtl/bb_check.sv
module bb_check #(
    parameter int unsigned VA_W = bb_pkg::VA_W_DEF,
    parameter int unsigned PA_W = bb_pkg::PA_W_DEF,
    parameter int unsigned BD_W = bb_pkg::BD_W_DEF
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  logic [PA_W-1:0] base_i,
    input  logic [BD_W-1:0] bound_i,
    output logic            legal_o,
    output logic [PA_W-1:0] paddr_o
);
    logic [BD_W-1:0] vext;

    always_comb begin
        vext    = BD_W'(vaddr_i);
        legal_o = (vext < bound_i);
        paddr_o = base_i + PA_W'(vaddr_i);
    end
endmodule

// File: rtl/bb_xlate.sv
module bb_xlate #(
    parameter int unsigned VA_W = bb_pkg::VA_W_DEF,
    parameter int unsigned PA_W = bb_pkg::PA_W_DEF,
    parameter int unsigned BD_W = VA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            priv_i,
    input  logic            cfg_we_i,
    input  logic [PA_W-1:0] cfg_base_i,
    input  logic [BD_W-1:0] cfg_bound_i,
    output logic [PA_W-1:0] cfg_base_o,
    output logic [BD_W-1:0] cfg_bound_o,
    input  logic            req_valid_i,
    input  logic [VA_W-1:0] req_vaddr_i,
    input  logic            req_write_i,
    output logic            mem_valid_o,
    output logic [PA_W-1:0] mem_paddr_o,
    output logic            mem_write_o,
    output logic            fault_bounds_o,
    output logic            fault_priv_o
);
    import bb_pkg::*;

    typedef struct packed {
        logic            valid;
        acc_kind_e       kind;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } pipe_t;

    logic [PA_W-1:0] base_q;
    logic [BD_W-1:0] bound_q;
    logic            legal;
    logic [PA_W-1:0] paddr_c;
    pipe_t           pipe_d, pipe_q;

    bb_regs #(.PA_W(PA_W), .BD_W(BD_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .priv_i       (priv_i),
        .we_i         (cfg_we_i),
        .base_i       (cfg_base_i),
        .bound_i      (cfg_bound_i),
        .base_o       (base_q),
        .bound_o      (bound_q),
        .priv_fault_o (fault_priv_o)
    );

    bb_check #(.VA_W(VA_W), .PA_W(PA_W), .BD_W(BD_W)) u_check (
        .vaddr_i (req_vaddr_i),
        .base_i  (base_q),
        .bound_i (bound_q),
        .legal_o (legal),
        .paddr_o (paddr_c)
    );

    always_comb begin
        pipe_d       = '0;
        pipe_d.kind  = ACC_LOAD;
        if (req_valid_i) begin
            if (legal) begin
                pipe_d.valid = 1'b1;
                pipe_d.kind  = req_write_i ? ACC_STORE : ACC_LOAD;
                pipe_d.paddr = paddr_c;
            end else begin
                pipe_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign mem_valid_o    = pipe_q.valid;
    assign mem_write_o    = (pipe_q.kind == ACC_STORE);
    assign mem_paddr_o    = pipe_q.paddr;
    assign fault_bounds_o = pipe_q.fault;
    assign cfg_base_o     = priv_i ? base_q  : '0;
    assign cfg_bound_o    = priv_i ? bound_q : '0;

    // R2: a fault never coexists with a memory request
    assert_fault_blocks_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_bounds_o && mem_valid_o));

    // R1: in-range request is relocated one cycle later
    assert_relocate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (BD_W'(req_vaddr_i) < bound_q)) |=>
        mem_valid_o && mem_paddr_o == $past(base_q) + PA_W'($past(req_vaddr_i))
        && mem_write_o == $past(req_write_i));

    // R2: out-of-range request faults one cycle later
    assert_out_of_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (BD_W'(req_vaddr_i) >= bound_q)) |=> fault_bounds_o && !mem_valid_o);

    // R8: idle cycle yields nothing
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !mem_valid_o && !fault_bounds_o);
endmodule

// File: tb/sim_bb_xlate.sv
`timescale 1ns/1ps
module sim_bb_xlate;
    localparam int VA_W = 6;
    localparam int PA_W = 8;
    localparam int BD_W = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            priv = 1'b0;
    logic            cfg_we = 1'b0;
    logic [PA_W-1:0] cfg_base = '0;
    logic [BD_W-1:0] cfg_bound = '0;
    logic [PA_W-1:0] rb_base;
    logic [BD_W-1:0] rb_bound;
    logic            req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic            req_write = 1'b0;
    logic            mem_valid;
    logic [PA_W-1:0] mem_paddr;
    logic            mem_write;
    logic            fault_bounds;
    logic            fault_priv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .BD_W(BD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .priv_i(priv),
        .cfg_we_i(cfg_we), .cfg_base_i(cfg_base), .cfg_bound_i(cfg_bound),
        .cfg_base_o(rb_base), .cfg_bound_o(rb_bound),
        .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
        .mem_valid_o(mem_valid), .mem_paddr_o(mem_paddr), .mem_write_o(mem_write),
        .fault_bounds_o(fault_bounds), .fault_priv_o(fault_priv)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one access; inputs set at a falling edge, outputs read at the next one
    task automatic access(input int v, input bit wr, input bit pv,
                          input int base, input int bound, input string tag);
        req_valid = 1'b1;
        req_vaddr = v[VA_W-1:0];
        req_write = wr;
        priv      = pv;
        @(negedge clk);
        req_valid = 1'b0;
        if (v < bound) begin
            check({tag, " valid"}, int'(mem_valid), 1);
            check({tag, " paddr"}, int'(mem_paddr), (base + v) % (1 << PA_W));
            check({tag, " write"}, int'(mem_write), int'(wr));
            check({tag, " nofault"}, int'(fault_bounds), 0);
        end else begin
            check({tag, " blocked"}, int'(mem_valid), 0);
            check({tag, " fault"}, int'(fault_bounds), 1);
        end
    endtask

    task automatic configure(input int base, input int bound, input bit pv);
        cfg_we    = 1'b1;
        cfg_base  = base[PA_W-1:0];
        cfg_bound = bound[BD_W-1:0];
        priv      = pv;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R5 priv fault on write", int'(fault_priv), int'(!pv));
        @(negedge clk);
        check("R5 priv fault single cycle", int'(fault_priv), 0);
    endtask

    task automatic readback(input int base, input int bound);
        priv = 1'b1;
        #1;
        check("R7 base readback", int'(rb_base), base);
        check("R7 bound readback", int'(rb_bound), bound);
        priv = 1'b0;
        #1;
        check("R7 base hidden in user mode", int'(rb_base), 0);
        check("R7 bound hidden in user mode", int'(rb_bound), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        check("R6 mem_valid after reset", int'(mem_valid), 0);
        check("R6 fault_bounds after reset", int'(fault_bounds), 0);
        check("R6 fault_priv after reset", int'(fault_priv), 0);
        readback(0, 0);
        access(0, 1'b0, 1'b0, 0, 0, "R6 zero bounds faults");
        access(0, 1'b0, 1'b1, 0, 0, "R6 zero bounds faults privileged");

        // R5: user-mode write is refused
        configure(5, 10, 1'b0);
        readback(0, 0);
        access(3, 1'b0, 1'b0, 0, 0, "R5 still faulting after refused write");

        // R4: privileged write, then sweep with base 16 / bound 4 (R1, R2, R3)
        configure(16, 4, 1'b1);
        readback(16, 4);
        for (int v = 0; v < (1 << VA_W); v++)
            access(v, v[0], v[1], 16, 4, "R1 R2 R3 sweep small bound");

        // R8: idle cycle
        @(negedge clk);
        check("R8 idle no request", int'(mem_valid), 0);
        check("R8 idle no fault", int'(fault_bounds), 0);

        // R4: same-cycle write and access uses the old values
        cfg_we = 1'b1; cfg_base = 8'd100; cfg_bound = 7'd64; priv = 1'b1;
        req_valid = 1'b1; req_vaddr = 6'd3; req_write = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R4 same-cycle old base", int'(mem_paddr), 19);
        check("R4 same-cycle old valid", int'(mem_valid), 1);
        access(3, 1'b0, 1'b0, 100, 64, "R4 new base next cycle");
        access(10, 1'b0, 1'b0, 100, 64, "R4 new bound next cycle");

        // R9 with wrap-around: base near top, full-size bound
        configure(250, 64, 1'b1);
        readback(250, 64);
        for (int v = 0; v < (1 << VA_W); v++)
            access(v, ~v[0], ~v[2], 250, 64, "R9 R1 full bound wrap sweep");

        // back to zero bounds: everything faults again
        configure(0, 0, 1'b1);
        for (int v = 0; v < (1 << VA_W); v += 7)
            access(v, 1'b0, 1'b0, 0, 0, "R2 zero bound sweep");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule